// File: doc/BRIEF.md
# CPU Hardware Trap Detector

This unit sits beside the decode stage of a 16-bit CPU pipeline and spots five hardware faults in the instruction that is being issued. The five faults are an undefined opcode, a protected system instruction whose redundant encoding is corrupt, a word data access at an odd byte address, a taken branch to an odd byte address, and an external bus access while no external bus is configured. Every fault it finds sets its own sticky bit in a flag register. One cycle after the detection cycle, the unit raises a single shared trap request. It also registers the return address that the stack-push logic must save, and that address depends on the kind of fault.

Protected system instructions carry their own check bytes. There are six of them: disable watchdog, end of init, idle, power down, software reset and service watchdog. For each one, the byte after the opcode must be the bitwise inverse of the opcode, and the second 16-bit word must hold the opcode in both bytes. The instruction word is 32 bits wide. The opcode is in bits [7:0], the check byte in bits [15:8] and the second word in bits [31:16].

Control is a two-state machine. In `TS_IDLE` no request is pending. In `TS_RAISE` the request is driven for that one cycle. Both states go to `TS_RAISE` when a fault is detected in the current cycle and to `TS_IDLE` otherwise. So each faulting instruction gives exactly one request cycle, and back-to-back faults keep the machine in `TS_RAISE`. Software reads the flags at `trap_flags` and clears them through a write port.

Top module: `hw_trap_unit`

## Requirements
- R1: When `instr_valid` is high and the opcode has bit 7 set and low nibble 0xF, flag bit 0 (undefined opcode) is set and the return address is `cur_addr`.
- R2: The protected opcodes are 0xA5, 0xB5, 0x87, 0x97, 0xB7 and 0xA7. A protected instruction whose bits [15:8] are not the inverse of the opcode, or whose bits [31:16] are not the opcode in both bytes, sets flag bit 1 (protection fault) and returns to `cur_addr`. A correctly encoded protected instruction raises nothing.
- R3: A word data access (`data_req` and `data_is_word` both high) to an odd `data_addr` sets flag bit 2 and returns to `next_addr`. Byte accesses and even word accesses raise nothing.
- R4: A taken branch to an odd `branch_target` sets flag bit 3, and the return address is that odd target. Untaken branches and even targets raise nothing.
- R5: `ext_req` while `ext_bus_en` is low sets flag bit 4 and returns to `next_addr`.
- R6: `trap_req` is high in the cycle after each detection cycle and low otherwise. All faults found in one instruction set their flags in the same cycle.
- R7: When several faults coincide, the return address follows the first fault in this order: undefined opcode, protection fault, odd branch, odd operand, bus.
- R8: While `instr_valid` is low, no fault is detected, no flag is set and `trap_req` stays low.
- R9: Flags are sticky. Writing a 0 to a bit through `flag_wr_en`/`flag_wr_data` clears it, and writing a 1 has no effect.
- R10: A hardware set and a software clear of the same bit in the same cycle leave the bit set.
- R11: After reset, `trap_flags`, `trap_req` and `ret_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Issued instruction is valid this cycle |
| cur_addr | input | ADDR_W | Address of the issued instruction |
| next_addr | input | ADDR_W | Address of the following instruction |
| instr_word | input | 32 | Opcode byte, check byte, second word |
| data_req | input | 1 | Instruction makes a data read or write |
| data_is_word | input | 1 | Data access is word sized |
| data_addr | input | ADDR_W | Data operand byte address |
| branch_taken | input | 1 | Instruction branches |
| branch_target | input | ADDR_W | Branch destination byte address |
| ext_req | input | 1 | Instruction needs the external bus |
| ext_bus_en | input | 1 | An external bus configuration is enabled |
| flag_wr_en | input | 1 | Software write strobe for the flag register |
| flag_wr_data | input | 5 | Write data, a 0 bit clears that flag |
| trap_req | output | 1 | Shared trap request, one cycle per faulting instruction |
| ret_addr | output | ADDR_W | Return address to be stacked |
| trap_flags | output | 5 | Sticky fault flags |

## Verification
The hardest case to reach from the ports is a hardware set and a software clear of the same flag bit landing on the same clock edge. The bench drives a faulting instruction and a zero write to the flag port in one cycle. It then checks that the bit survives, and that other bits named in the same write are cleared. Fault coincidence is reached through table rows that combine two faults in one instruction. These rows also exercise the priority of the return address.

// File: rtl/hw_trap_pkg.sv
package hw_trap_pkg;

    localparam int NUM_TRAPS = 5;
    localparam int INSN_W    = 32;
    localparam int OPC_W     = 8;
    localparam int NUM_PROT  = 6;

    // Flag bit positions (software visible)
    localparam int F_UNDEF = 0;
    localparam int F_PROT  = 1;
    localparam int F_OPND  = 2;
    localparam int F_INSN  = 3;
    localparam int F_BUS   = 4;

    typedef logic [NUM_TRAPS-1:0] trap_vec_t;

    typedef enum logic [0:0] {
        TS_IDLE  = 1'b0,
        TS_RAISE = 1'b1
    } ts_state_t;

    typedef enum logic [1:0] {
        RS_CUR  = 2'd0,
        RS_NEXT = 2'd1,
        RS_TGT  = 2'd2
    } ret_src_t;

    // Protected system opcodes: disable watchdog, end of init, idle,
    // power down, software reset, service watchdog.
    localparam logic [OPC_W-1:0] PROT_OPC [NUM_PROT] = '{
        8'hA5, 8'hB5, 8'h87, 8'h97, 8'hB7, 8'hA7
    };

    function automatic ret_src_t pick_src(input trap_vec_t ev);
        ret_src_t s;
        s = RS_NEXT;
        if (ev[F_UNDEF] || ev[F_PROT]) s = RS_CUR;
        else if (ev[F_INSN])           s = RS_TGT;
        else                           s = RS_NEXT;
        return s;
    endfunction

endpackage

// File: rtl/hw_trap_decode.sv
module hw_trap_decode
    import hw_trap_pkg::*;
(
    input  logic [INSN_W-1:0] instr_word,
    output logic              undef_opc,
    output logic              prot_fault
);

    localparam int HALF_W = INSN_W / 2;

    logic [OPC_W-1:0]  opc;
    logic [OPC_W-1:0]  chk_byte;
    logic [HALF_W-1:0] second_word;
    logic [NUM_PROT-1:0] hit;
    logic              is_prot;
    logic              enc_ok;

    assign opc         = instr_word[OPC_W-1:0];
    assign chk_byte    = instr_word[2*OPC_W-1:OPC_W];
    assign second_word = instr_word[INSN_W-1:HALF_W];

    generate
        for (genvar g = 0; g < NUM_PROT; g++) begin : g_prot
            assign hit[g] = (opc == PROT_OPC[g]);
        end
    endgenerate

    always_comb begin
        is_prot   = |hit;
        enc_ok    = (chk_byte == ~opc) && (second_word == {opc, opc});
        undef_opc = opc[OPC_W-1] && (opc[3:0] == 4'hF);
        prot_fault = is_prot && !enc_ok;
    end

endmodule

// File: rtl/hw_trap_access_chk.sv
module hw_trap_access_chk #(
    parameter int ADDR_W = 24
) (
    input  logic              data_req,
    input  logic              data_is_word,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic              branch_taken,
    input  logic [ADDR_W-1:0] branch_target,
    input  logic              ext_req,
    input  logic              ext_bus_en,
    output logic              opnd_fault,
    output logic              insn_fault,
    output logic              bus_fault
);

    logic unused_addr_hi;
    assign unused_addr_hi = ^{data_addr[ADDR_W-1:1], branch_target[ADDR_W-1:1]};

    always_comb begin
        opnd_fault = data_req && data_is_word && data_addr[0];
        insn_fault = branch_taken && branch_target[0];
        bus_fault  = ext_req && !ext_bus_en;
    end

endmodule

// File: rtl/hw_trap_flag_reg.sv
module hw_trap_flag_reg #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_mask,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    output logic [N-1:0] flags
);

    logic [N-1:0] clr_mask;
    logic [N-1:0] flags_nx;

    always_comb begin
        clr_mask = wr_en ? ~wr_data : '0;
        flags_nx = (flags & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_nx;
    end

    // R9
    sticky_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((flags & $past(flags)) == $past(flags)));

    // R9
    one_bits_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data == '1)) |=> ((flags & $past(flags)) == $past(flags)));

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((flags & $past(set_mask)) == $past(set_mask)));

endmodule

// File: rtl/hw_trap_unit.sv
module hw_trap_unit
    import hw_trap_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [31:0]       instr_word,
    input  logic              data_req,
    input  logic              data_is_word,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic              branch_taken,
    input  logic [ADDR_W-1:0] branch_target,
    input  logic              ext_req,
    input  logic              ext_bus_en,
    input  logic              flag_wr_en,
    input  logic [4:0]        flag_wr_data,
    output logic              trap_req,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [4:0]        trap_flags
);

    logic      undef_opc, prot_fault;
    logic      opnd_fault, insn_fault, bus_fault;
    trap_vec_t raw_ev, ev;
    logic      any_ev;
    ret_src_t  src;
    logic [ADDR_W-1:0] ret_nx;
    ts_state_t state, state_nx;

    hw_trap_decode u_decode (
        .instr_word (instr_word),
        .undef_opc  (undef_opc),
        .prot_fault (prot_fault)
    );

    hw_trap_access_chk #(.ADDR_W(ADDR_W)) u_access (
        .data_req      (data_req),
        .data_is_word  (data_is_word),
        .data_addr     (data_addr),
        .branch_taken  (branch_taken),
        .branch_target (branch_target),
        .ext_req       (ext_req),
        .ext_bus_en    (ext_bus_en),
        .opnd_fault    (opnd_fault),
        .insn_fault    (insn_fault),
        .bus_fault     (bus_fault)
    );

    always_comb begin
        raw_ev          = '0;
        raw_ev[F_UNDEF] = undef_opc;
        raw_ev[F_PROT]  = prot_fault;
        raw_ev[F_OPND]  = opnd_fault;
        raw_ev[F_INSN]  = insn_fault;
        raw_ev[F_BUS]   = bus_fault;
        ev              = instr_valid ? raw_ev : '0;
        any_ev          = |ev;
        src             = pick_src(ev);
        unique case (src)
            RS_CUR:  ret_nx = cur_addr;
            RS_TGT:  ret_nx = branch_target;
            default: ret_nx = next_addr;
        endcase
    end

    hw_trap_flag_reg #(.N(NUM_TRAPS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (ev),
        .wr_en    (flag_wr_en),
        .wr_data  (flag_wr_data),
        .flags    (trap_flags)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TS_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        unique case (state)
            TS_IDLE:  state_nx = any_ev ? TS_RAISE : TS_IDLE;
            TS_RAISE: state_nx = any_ev ? TS_RAISE : TS_IDLE;
            default:  state_nx = TS_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ret_addr <= '0;
        else if (any_ev) ret_addr <= ret_nx;
    end

    assign trap_req = (state == TS_RAISE);

    // R8
    no_trap_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !trap_req);

    // R6
    req_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_flags != '0));

    // R4
    odd_branch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && branch_taken && branch_target[0]) |=> (trap_req && trap_flags[F_INSN]));

    // R7
    branch_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && insn_fault && !undef_opc && !prot_fault) |=> (ret_addr == $past(branch_target)));

endmodule

// File: tb/hw_trap_unit_bench.sv
`timescale 1ns/1ps
module hw_trap_unit_bench;

    localparam int AW = 24;
    localparam logic [AW-1:0] CUR = 24'h000100;
    localparam logic [AW-1:0] NXT = 24'h000104;

    typedef struct packed {
        logic [31:0]   insn;
        logic          dreq;
        logic          wrd;
        logic [AW-1:0] oaddr;
        logic          br;
        logic [AW-1:0] tgt;
        logic          ext;
        logic          cfg;
        logic [4:0]    xflags;
        logic [AW-1:0] xret;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_0000, 1'b0, 1'b0, 24'h0, 1'b0, 24'h0,      1'b0, 1'b1, 5'b00000, 24'h0},   // plain
        '{32'h0000_008F, 1'b0, 1'b0, 24'h0, 1'b0, 24'h0,      1'b0, 1'b1, 5'b00001, CUR},     // R1
        '{32'h8787_7887, 1'b0, 1'b0, 24'h0, 1'b0, 24'h0,      1'b0, 1'b1, 5'b00000, 24'h0},   // R2 good
        '{32'h8787_7787, 1'b0, 1'b0, 24'h0, 1'b0, 24'h0,      1'b0, 1'b1, 5'b00010, CUR},     // R2 bad byte
        '{32'hA7A6_58A7, 1'b0, 1'b0, 24'h0, 1'b0, 24'h0,      1'b0, 1'b1, 5'b00010, CUR},     // R2 bad word
        '{32'h0, 1'b1, 1'b1, 24'h000203, 1'b0, 24'h0,         1'b0, 1'b1, 5'b00100, NXT},     // R3
        '{32'h0, 1'b1, 1'b0, 24'h000203, 1'b0, 24'h0,         1'b0, 1'b1, 5'b00000, 24'h0},   // R3 byte
        '{32'h0, 1'b1, 1'b1, 24'h000202, 1'b0, 24'h0,         1'b0, 1'b1, 5'b00000, 24'h0},   // R3 even
        '{32'h0, 1'b0, 1'b0, 24'h0, 1'b1, 24'h001235,         1'b0, 1'b1, 5'b01000, 24'h001235}, // R4
        '{32'h0, 1'b0, 1'b0, 24'h0, 1'b1, 24'h001234,         1'b0, 1'b1, 5'b00000, 24'h0},   // R4 even
        '{32'h0, 1'b0, 1'b0, 24'h0, 1'b0, 24'h001235,         1'b0, 1'b1, 5'b00000, 24'h0},   // R4 not taken
        '{32'h0, 1'b0, 1'b0, 24'h0, 1'b0, 24'h0,              1'b1, 1'b0, 5'b10000, NXT},     // R5
        '{32'h0, 1'b0, 1'b0, 24'h0, 1'b0, 24'h0,              1'b1, 1'b1, 5'b00000, 24'h0},   // R5 cfg
        '{32'h0, 1'b1, 1'b1, 24'h000301, 1'b0, 24'h0,         1'b1, 1'b0, 5'b10100, NXT},     // R6 R7
        '{32'h0000_009F, 1'b0, 1'b0, 24'h0, 1'b1, 24'h000777, 1'b0, 1'b1, 5'b01001, CUR},     // R7
        '{32'h0, 1'b1, 1'b1, 24'h000301, 1'b1, 24'h000889,    1'b0, 1'b1, 5'b01100, 24'h000889} // R7
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic instr_valid = 1'b0;
    logic [AW-1:0] cur_addr = CUR;
    logic [AW-1:0] next_addr = NXT;
    logic [31:0] instr_word = '0;
    logic data_req = 1'b0, data_is_word = 1'b0;
    logic [AW-1:0] data_addr = '0;
    logic branch_taken = 1'b0;
    logic [AW-1:0] branch_target = '0;
    logic ext_req = 1'b0, ext_bus_en = 1'b1;
    logic flag_wr_en = 1'b0;
    logic [4:0] flag_wr_data = '0;
    logic trap_req;
    logic [AW-1:0] ret_addr;
    logic [4:0] trap_flags;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    hw_trap_unit #(.ADDR_W(AW)) u_hw_trap_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .cur_addr(cur_addr), .next_addr(next_addr), .instr_word(instr_word),
        .data_req(data_req), .data_is_word(data_is_word), .data_addr(data_addr),
        .branch_taken(branch_taken), .branch_target(branch_target),
        .ext_req(ext_req), .ext_bus_en(ext_bus_en),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .trap_req(trap_req), .ret_addr(ret_addr), .trap_flags(trap_flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        instr_valid = 1'b0; instr_word = '0; data_req = 1'b0; data_is_word = 1'b0;
        data_addr = '0; branch_taken = 1'b0; branch_target = '0;
        ext_req = 1'b0; ext_bus_en = 1'b1; flag_wr_en = 1'b0; flag_wr_data = '0;
    endtask

    task automatic clear_all();
        @(negedge clk); idle_inputs(); flag_wr_en = 1'b1; flag_wr_data = 5'b0;
        @(negedge clk); flag_wr_en = 1'b0;
    endtask

    task automatic issue_undef();
        instr_valid = 1'b1; instr_word = 32'h0000_00FF;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 flags", {27'b0, trap_flags}, 32'h0);
        chk("R11 req", {31'b0, trap_req}, 32'h0);
        chk("R11 ret", {8'b0, ret_addr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            instr_valid = 1'b1; instr_word = VEC[i].insn;
            data_req = VEC[i].dreq; data_is_word = VEC[i].wrd; data_addr = VEC[i].oaddr;
            branch_taken = VEC[i].br; branch_target = VEC[i].tgt;
            ext_req = VEC[i].ext; ext_bus_en = VEC[i].cfg;
            @(posedge clk); #1;
            chk($sformatf("R6 vec%0d req", i), {31'b0, trap_req}, {31'b0, VEC[i].xflags != 0});
            chk($sformatf("R1-5 vec%0d flags", i), {27'b0, trap_flags}, {27'b0, VEC[i].xflags});
            if (VEC[i].xflags != 0)
                chk($sformatf("R7 vec%0d ret", i), {8'b0, ret_addr}, {8'b0, VEC[i].xret});
            clear_all();
            // R6 request lasts one cycle
            chk($sformatf("R6 vec%0d req drop", i), {31'b0, trap_req}, 32'h0);
        end

        // R8 invalid instruction ignored
        @(negedge clk); idle_inputs(); instr_word = 32'h0000_008F;
        ext_req = 1'b1; ext_bus_en = 1'b0; branch_taken = 1'b1; branch_target = 24'h11;
        @(posedge clk); #1;
        chk("R8 req", {31'b0, trap_req}, 32'h0);
        chk("R8 flags", {27'b0, trap_flags}, 32'h0);

        // R9 sticky and write-one ignored
        @(negedge clk); idle_inputs(); issue_undef();
        @(negedge clk); idle_inputs();
        repeat (3) @(negedge clk);
        chk("R9 sticky", {27'b0, trap_flags}, 32'h1);
        flag_wr_en = 1'b1; flag_wr_data = 5'b11111;
        @(negedge clk); flag_wr_en = 1'b0;
        chk("R9 write one", {27'b0, trap_flags}, 32'h1);
        // set bus flag too, then clear only undef
        ext_req = 1'b1; ext_bus_en = 1'b0; instr_valid = 1'b1;
        @(negedge clk); idle_inputs();
        chk("R9 two flags", {27'b0, trap_flags}, 32'h11);
        flag_wr_en = 1'b1; flag_wr_data = 5'b11110;
        @(negedge clk); flag_wr_en = 1'b0;
        chk("R9 partial clear", {27'b0, trap_flags}, 32'h10);

        // R10 set wins over clear in same cycle
        issue_undef(); flag_wr_en = 1'b1; flag_wr_data = 5'b00000;
        @(negedge clk); idle_inputs();
        chk("R10 set wins", {27'b0, trap_flags}, 32'h1);

        // R6 back-to-back faults keep request high two cycles
        clear_all();
        issue_undef();
        @(posedge clk); #1;
        chk("R6 b2b first", {31'b0, trap_req}, 32'h1);
        @(negedge clk); instr_word = 32'h0; ext_req = 1'b1; ext_bus_en = 1'b0;
        @(posedge clk); #1;
        chk("R6 b2b second", {31'b0, trap_req}, 32'h1);
        chk("R5 b2b ret", {8'b0, ret_addr}, {8'b0, NXT});
        chk("R6 b2b flags", {27'b0, trap_flags}, 32'h11);
        @(negedge clk); idle_inputs();
        @(posedge clk); #1;
        chk("R6 b2b end", {31'b0, trap_req}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule